// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This block sits in front of a floating-point arithmetic pipeline that handles add, subtract, multiply, divide, square root and fused multiply-add. For every operation it works out whether the answer is already fixed by the operand classes. That happens when a NaN has to be propagated, or when the operation is invalid and must give the default NaN. In those cases it raises a bypass flag together with the finished result, and the arithmetic datapath's output is discarded. Otherwise it leaves the bypass flag low and the datapath computes normally.

For fused multiply-add the block also handles the sign of an exactly-zero result. When the addend is zero and either factor is zero, it supplies the finished signed zero. It also exports the product sign, which the datapath needs when the addend is zero and a rounded result comes out as zero. The negated multiply-add forms are selected by two sign-flip inputs. These act on the addend and on the first factor before any resolution takes place.

The operands are 64-bit buses. In single precision only the low 32 bits are used, and every result is zero-extended to 64 bits. Results are registered, so they appear one clock after the request.

Top module: `fp_special_resolver`

## Requirements
- R1: For add (op 0), subtract (op 1), multiply (op 2) and divide (op 3), the NaN chosen is picked in this order: signalling NaN in `opnd_n`, signalling NaN in `opnd_m`, quiet NaN in `opnd_n`, quiet NaN in `opnd_m`. The output keeps the chosen NaN's sign and payload and sets the quiet bit (bit 22 in single, bit 51 in double). A NaN has an all-ones exponent and a nonzero fraction, and it is quiet when the fraction MSB is 1.
- R2: For fused multiply-add (op 5), every signalling NaN wins over every quiet NaN. Within each kind the order is addend, then `opnd_n`, then `opnd_m`. The chosen NaN is quieted as in R1.
- R3: While `dn_mode` is 1, every bypass result is the default NaN: 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.
- R4: Adding infinities of opposite sign, or subtracting infinities of the same sign, gives a bypass with the default NaN.
- R5: Infinity times zero, in either order, gives a bypass with the default NaN. So do infinity divided by infinity and zero divided by zero.
- R6: Square root (op 4, operand `opnd_n`) has three cases. A NaN is propagated quieted. A negative nonzero non-NaN value gives the default NaN. Negative zero gives no bypass.
- R7: Fused multiply-add is invalid when the product is infinity times zero, or when the addend is infinite and the product is infinite with the opposite sign. An invalid operation gives the default NaN. This also holds when the addend is a quiet NaN that would otherwise be propagated.
- R8: For fused multiply-add without bypass, suppose the addend is zero and either factor is zero. Then `zero_force` is 1 and `zero_result` is a zero whose sign is 1 only when the addend and the product are both negative.
- R9: For fused multiply-add, `prod_sign` equals the XOR of the sign bits of the factors after negation. For every other op it is 0.
- R10: `neg_addend` flips the addend sign and `neg_product` flips the `opnd_n` sign before NaN selection and invalid checks. These inputs act only for op 5.
- R11: When `dbl` is 0, bits 63:32 of the operands are ignored and bits 63:32 of every result are 0. Opcodes 6 and 7 never raise bypass or `zero_force`.
- R12: Results appear one clock after a request with `in_valid`. While `out_valid` is 0, including after reset, `bypass`, `zero_force` and `prod_sign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 fused multiply-add |
| dbl | input | 1 | 1 double precision, 0 single precision |
| dn_mode | input | 1 | Replace every propagated NaN with the default NaN |
| neg_addend | input | 1 | Negate the addend (multiply-add only) |
| neg_product | input | 1 | Negate the first factor (multiply-add only) |
| addend | input | 64 | Multiply-add addend |
| opnd_n | input | 64 | First operand / first factor / square-root operand |
| opnd_m | input | 64 | Second operand / second factor |
| out_valid | output | 1 | Result registers hold a request |
| bypass | output | 1 | Result fully determined by special operands |
| bypass_result | output | 64 | NaN result when bypass is set |
| zero_force | output | 1 | Multiply-add exact zero result is forced |
| zero_result | output | 64 | Signed zero to use when zero_force is set |
| prod_sign | output | 1 | Product sign for the rounded-zero sign rule |

## Verification
The in-line assertions check rules that hold on every cycle. Any bypass result is a quiet NaN. Default-NaN mode always yields the exact default pattern. Single-precision results are zero-extended. A forced zero never coexists with bypass and is a true zero. Reserved opcodes and idle cycles produce nothing. The priority orderings, the invalid-operation rules, the override of a quiet addend NaN by an invalid product, and the zero-sign combinations need particular operand mixes. Only the bench's sweep over operand classes, signs, negations, precisions and modes can show those.

// File: rtl/fp_special_resolver.sv
module fp_special_resolver (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic        dbl,
  input  logic        dn_mode,
  input  logic        neg_addend,
  input  logic        neg_product,
  input  logic [63:0] addend,
  input  logic [63:0] opnd_n,
  input  logic [63:0] opnd_m,
  output logic        out_valid,
  output logic        bypass,
  output logic [63:0] bypass_result,
  output logic        zero_force,
  output logic [63:0] zero_result,
  output logic        prod_sign
);

  typedef struct packed {
    logic s;
    logic z;
    logic inf;
    logic qn;
    logic sn;
  } fcls_t;

  function automatic fcls_t classify(input logic [63:0] v, input logic d);
    fcls_t c;
    logic  e1, e0, fnz, qb;
    e1  = d ? (&v[62:52]) : (&v[30:23]);
    e0  = d ? ~(|v[62:52]) : ~(|v[30:23]);
    fnz = d ? (|v[51:0]) : (|v[22:0]);
    qb  = d ? v[51] : v[22];
    c.s   = d ? v[63] : v[31];
    c.z   = e0 & ~fnz;
    c.inf = e1 & ~fnz;
    c.qn  = e1 & qb;
    c.sn  = e1 & fnz & ~qb;
    return c;
  endfunction

  logic        is_fma, is_two, is_sqrt;
  logic [63:0] smask, qmask, dnan;
  logic [63:0] a_w, n_w, m_w;
  fcls_t       ca, cn, cm;

  assign is_fma  = (op == 3'd5);
  assign is_two  = (op < 3'd4);
  assign is_sqrt = (op == 3'd4);
  assign smask   = dbl ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
  assign qmask   = dbl ? 64'h0008_0000_0000_0000 : 64'h0000_0000_0040_0000;
  assign dnan    = dbl ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;

  assign a_w = (dbl ? addend : {32'b0, addend[31:0]}) ^ ((is_fma & neg_addend) ? smask : 64'b0);
  assign n_w = (dbl ? opnd_n : {32'b0, opnd_n[31:0]}) ^ ((is_fma & neg_product) ? smask : 64'b0);
  assign m_w =  dbl ? opnd_m : {32'b0, opnd_m[31:0]};

  assign ca = classify(a_w, dbl);
  assign cn = classify(n_w, dbl);
  assign cm = classify(m_w, dbl);

  logic        nan_hit;
  logic [63:0] nan_src;

  always_comb begin
    nan_hit = 1'b1;
    nan_src = 64'b0;
    if (is_fma) begin
      if      (ca.sn) nan_src = a_w;
      else if (cn.sn) nan_src = n_w;
      else if (cm.sn) nan_src = m_w;
      else if (ca.qn) nan_src = a_w;
      else if (cn.qn) nan_src = n_w;
      else if (cm.qn) nan_src = m_w;
      else            nan_hit = 1'b0;
    end else if (is_two) begin
      if      (cn.sn) nan_src = n_w;
      else if (cm.sn) nan_src = m_w;
      else if (cn.qn) nan_src = n_w;
      else if (cm.qn) nan_src = m_w;
      else            nan_hit = 1'b0;
    end else if (is_sqrt) begin
      if (cn.sn | cn.qn) nan_src = n_w;
      else               nan_hit = 1'b0;
    end else begin
      nan_hit = 1'b0;
    end
  end

  logic psign, inf_by_zero, invalid;

  assign psign       = cn.s ^ cm.s;
  assign inf_by_zero = (cn.inf & cm.z) | (cm.inf & cn.z);

  always_comb begin
    unique case (op)
      3'd0:    invalid = cn.inf & cm.inf & (cn.s != cm.s);
      3'd1:    invalid = cn.inf & cm.inf & (cn.s == cm.s);
      3'd2:    invalid = inf_by_zero;
      3'd3:    invalid = (cn.inf & cm.inf) | (cn.z & cm.z);
      3'd4:    invalid = cn.s & ~cn.z & ~cn.qn & ~cn.sn;
      3'd5:    invalid = inf_by_zero | (ca.inf & (cn.inf | cm.inf) & (ca.s != psign));
      default: invalid = 1'b0;
    endcase
  end

  logic        byp_c, fz_c, fz_sign;
  logic [63:0] res_c, zres_c;

  assign byp_c   = nan_hit | invalid;
  assign res_c   = (dn_mode | ~nan_hit | (is_fma & invalid & ca.qn)) ? dnan : (nan_src | qmask);
  assign fz_c    = is_fma & ~byp_c & ca.z & (cn.z | cm.z);
  assign fz_sign = ca.s & psign;
  assign zres_c  = dbl ? {fz_sign, 63'b0} : {32'b0, fz_sign, 31'b0};

  logic dbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      bypass        <= 1'b0;
      bypass_result <= 64'b0;
      zero_force    <= 1'b0;
      zero_result   <= 64'b0;
      prod_sign     <= 1'b0;
      dbl_q         <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      bypass        <= in_valid & byp_c;
      bypass_result <= in_valid & byp_c ? res_c : 64'b0;
      zero_force    <= in_valid & fz_c;
      zero_result   <= in_valid & fz_c ? zres_c : 64'b0;
      prod_sign     <= in_valid & is_fma & psign;
      dbl_q         <= dbl;
    end
  end

  // R1
  bypass_quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (dbl_q ? (&bypass_result[62:51]) : (&bypass_result[30:22])));

  // R3
  default_nan_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(dn_mode)) |->
      bypass_result == ($past(dbl) ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000));

  // R11
  single_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dbl_q) |-> (bypass_result[63:32] == 32'b0 && zero_result[63:32] == 32'b0));

  // R11
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) > 3'd5) |-> (!bypass && !zero_force));

  // R8
  forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_force |-> (!bypass && (zero_result & 64'h7FFF_FFFF_7FFF_FFFF) == 64'b0));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!bypass && !zero_force && !prod_sign));

endmodule

// File: tb/test_fp_special_resolver.sv
module test_fp_special_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic dbl = 1'b0, dn_mode = 1'b0, neg_addend = 1'b0, neg_product = 1'b0;
  logic [63:0] addend = 64'b0, opnd_n = 64'b0, opnd_m = 64'b0;
  logic out_valid, bypass, zero_force, prod_sign;
  logic [63:0] bypass_result, zero_result;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_special_resolver i_fp_special_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dbl(dbl),
    .dn_mode(dn_mode), .neg_addend(neg_addend), .neg_product(neg_product),
    .addend(addend), .opnd_n(opnd_n), .opnd_m(opnd_m),
    .out_valid(out_valid), .bypass(bypass), .bypass_result(bypass_result),
    .zero_force(zero_force), .zero_result(zero_result), .prod_sign(prod_sign));

  // value classes by index: 0 +0, 1 -0, 2 +1.0, 3 -2.0, 4 +inf, 5 -inf, 6 +qNaN, 7 -sNaN
  function automatic logic [63:0] mkval(input int i, input logic s, input logic d);
    logic [63:0] mag;
    case (i)
      0, 1: mag = 64'b0;
      2:    mag = d ? 64'h3FF0_0000_0000_0000 : 64'h3F80_0000;
      3:    mag = d ? 64'h4000_0000_0000_0000 : 64'h4000_0000;
      4, 5: mag = d ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000;
      6:    mag = d ? 64'h7FF8_0000_0000_0005 : 64'h7FC0_0005;
      default: mag = d ? 64'h7FF0_0000_0000_0003 : 64'h7F80_0003;
    endcase
    if (d) return mag | ({63'b0, s} << 63);
    return mag | ({63'b0, s} << 31);
  endfunction

  function automatic logic sgn(input int i); return (i % 2) == 1; endfunction
  function automatic logic isz(input int i); return i < 2; endfunction
  function automatic logic isi(input int i); return i == 4 || i == 5; endfunction
  function automatic logic isq(input int i); return i == 6; endfunction
  function automatic logic iss(input int i); return i == 7; endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int o, input logic d, input logic dn, input logic na,
                         input logic np, input int ia, input int in_, input int im);
    logic fma, sa, sn, sm, hit, inv, ebyp, efz;
    int src; logic ssrc;
    logic [63:0] qm, dnv, eres, ezr, garbage;
    fma = (o == 5);
    sa = sgn(ia) ^ (fma & na);
    sn = sgn(in_) ^ (fma & np);
    sm = sgn(im);
    qm  = d ? 64'h0008_0000_0000_0000 : 64'h40_0000;
    dnv = d ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
    hit = 1'b1; src = 0; ssrc = 1'b0;
    if (fma) begin
      if      (iss(ia)) begin src = ia;  ssrc = sa; end
      else if (iss(in_)) begin src = in_; ssrc = sn; end
      else if (iss(im)) begin src = im;  ssrc = sm; end
      else if (isq(ia)) begin src = ia;  ssrc = sa; end
      else if (isq(in_)) begin src = in_; ssrc = sn; end
      else if (isq(im)) begin src = im;  ssrc = sm; end
      else hit = 1'b0;
    end else if (o < 4) begin
      if      (iss(in_)) begin src = in_; ssrc = sn; end
      else if (iss(im)) begin src = im;  ssrc = sm; end
      else if (isq(in_)) begin src = in_; ssrc = sn; end
      else if (isq(im)) begin src = im;  ssrc = sm; end
      else hit = 1'b0;
    end else if (o == 4) begin
      if (iss(in_) || isq(in_)) begin src = in_; ssrc = sn; end
      else hit = 1'b0;
    end else hit = 1'b0;
    case (o)
      0: inv = isi(in_) && isi(im) && sn != sm;
      1: inv = isi(in_) && isi(im) && sn == sm;
      2: inv = (isi(in_) && isz(im)) || (isi(im) && isz(in_));
      3: inv = (isi(in_) && isi(im)) || (isz(in_) && isz(im));
      4: inv = sn && !isz(in_) && !isq(in_) && !iss(in_);
      5: inv = (isi(in_) && isz(im)) || (isi(im) && isz(in_)) ||
               (isi(ia) && (isi(in_) || isi(im)) && sa != (sn ^ sm));
      default: inv = 1'b0;
    endcase
    ebyp = hit || inv;
    if (!ebyp) eres = 64'b0;
    else if (dn || !hit || (fma && inv && isq(ia))) eres = dnv;
    else eres = mkval(src, ssrc, d) | qm;
    efz = fma && !ebyp && isz(ia) && (isz(in_) || isz(im));
    ezr = efz ? mkval(0, sa & (sn ^ sm), d) : 64'b0;
    garbage = d ? 64'b0 : 64'hA5C3_0F96_0000_0000;
    op = o[2:0]; dbl = d; dn_mode = dn; neg_addend = na; neg_product = np;
    addend = mkval(ia, sgn(ia), d) | garbage;
    opnd_n = mkval(in_, sgn(in_), d) | garbage;
    opnd_m = mkval(im, sgn(im), d) | garbage;
    in_valid = 1'b1;
    @(negedge clk);
    if (fma)
      check("R2,R7,R8,R9,R10 fma", {bypass, zero_force, prod_sign}, {ebyp, efz, sn ^ sm});
    else if (o > 5)
      check("R11 reserved", {bypass, zero_force, prod_sign}, 3'b000);
    else
      check("R1,R4,R5,R6 flags", {bypass, zero_force, prod_sign}, {ebyp, 2'b00});
    if (dn) check("R3 result", bypass_result, eres);
    else    check("R1,R2,R11 result", bypass_result, eres);
    if (fma) check("R8 zero", zero_result, ezr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", {out_valid, bypass, zero_force, prod_sign}, 4'b0);
    check("R12 reset result", bypass_result | zero_result, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      for (int dn = 0; dn < 2; dn++)
        for (int o = 0; o < 8; o++)
          if (o == 5) begin
            for (int ng = 0; ng < 4; ng++)
              for (int ia = 0; ia < 8; ia++)
                for (int in_ = 0; in_ < 8; in_++)
                  for (int im = 0; im < 8; im++)
                    run_vec(o, d[0], dn[0], ng[1], ng[0], ia, in_, im);
          end else begin
            for (int in_ = 0; in_ < 8; in_++)
              for (int im = 0; im < 8; im++)
                run_vec(o, d[0], dn[0], 1'b1, 1'b1, 0, in_, im);
          end
    in_valid = 1'b0;
    op = 3'd5; addend = 64'b0; opnd_n = 64'h8000_0000_0000_0000; opnd_m = 64'b0;
    @(negedge clk);
    check("R12 idle", {out_valid, bypass, zero_force, prod_sign}, 4'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule